// File: doc/BRIEF.md
# Power domain on/off sequencer

This block steps a single switchable power domain through an ordered power-down or power-up procedure. It owns every control line that touches the domain: the top-level power switch (sleep), the output isolation clamp, a bank of memory power-down fields, an active-high domain reset and a clock enable. Between the switch, memory and isolation steps it inserts fixed settle waits, counted in clock cycles from a cycles-per-microsecond parameter, and when the domain has clocks it waits a longer interval before it gates them.

Requests arrive on single-cycle on, off and shutdown strobes. The block raises busy while a sequence runs, pulses done for one cycle when it ends, and always reports whether the domain is powered. Parameters choose between a switched domain and a memory-only domain that has no switch or isolation, between a domain with or without clocks, and between a domain that starts powered off or powered on. A powered-on domain that has a switch and clocks enables its clocks on its own after reset and then refuses ordinary off requests. Only a shutdown request can take such a domain down.

Top module: `pwr_domain_seq`

## Requirements
- R1: With BOOT_ON=0, reset leaves sleep_o=1 and iso_o=1 (both 0 when HAS_SWITCH=0). Every used memory field is all ones and every unused bit of mem_pd_o is 0. dom_rst_o=0, clk_en_o=0, pwr_on_o=0, busy_o=0 and done_o=0. Field k occupies bits [FIELD_W*k+FIELD_W-1 : FIELD_W*k] of mem_pd_o, and fields are packed upward from bit 0 across WORD_W-bit words.
- R2: An accepted power-down sets sleep_o at the accepting edge. All used memory fields go to all ones S cycles later (S = CYC_PER_US*SETTLE_US). iso_o rises S cycles after that. With clocks, clk_en_o falls W cycles after isolation (W = CYC_PER_US*CLK_WAIT_US).
- R3: An accepted power-up clears sleep_o at the accepting edge. It clears all memory fields S cycles later and raises dom_rst_o S cycles after that. iso_o falls one cycle later, dom_rst_o falls one cycle after that, and clk_en_o rises one cycle after that.
- R4: busy_o is high from the cycle after the accepting edge until done_o pulses. done_o is high for exactly one cycle, the cycle in which the last output change becomes visible. Any request presented while busy_o is high is ignored.
- R5: An on request to a powered domain, or an off request to an unpowered domain, pulses done_o in the next cycle, changes no control output and never raises busy_o.
- R6: With HAS_SWITCH=0, sleep_o and iso_o stay 0. Both settle waits, the memory writes and the reset pulse still occur with the same cycle offsets as in R2 and R3.
- R7: pwr_on_o equals the inverse of sleep_o for a switched domain. For a memory-only domain it changes at the memory-field step of each sequence.
- R8: With BOOT_ON=1, HAS_SWITCH=1 and HAS_CLOCKS=1, reset leaves sleep_o, iso_o, memory fields and dom_rst_o at 0. clk_en_o rises one cycle after reset is released, and later off requests change nothing and produce no done_o.
- R9: A shutdown request takes a powered domain through the full R2 sequence even when R8 locks out off requests. Shutdown has priority over off, and off has priority over on, when strobes coincide.
- R10: With HAS_CLOCKS=0, the power-down ends with done_o at the isolation step, with no clock wait, and clk_en_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| on_req_i | input | 1 | Power-up request strobe |
| off_req_i | input | 1 | Power-down request strobe |
| shutdown_i | input | 1 | Shutdown strobe; overrides the always-on lock |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pwr_on_o | output | 1 | Domain powered status |
| sleep_o | output | 1 | Top-level switch control, 1 = switched off |
| iso_o | output | 1 | Output isolation, 1 = isolated |
| mem_pd_o | output | MEM_W | Memory power-down fields, 1 = powered down |
| dom_rst_o | output | 1 | Domain reset, active high |
| clk_en_o | output | 1 | Domain clock enable |

## Verification
An off-by-one in the settle counter moves the memory-field edge, and every later edge, by one cycle from the accepting edge. This shows at the ports within S cycles of the request. A skipped or misordered step shows up by the end of the same sequence: a missing reset pulse, isolation released while reset is low, or clocks enabled while still isolated. A lost lock or a stale status bit does not show until the next request, which then either changes the outputs when it must not or pulses done at once instead of running a sequence. The bench therefore records, for every control output, the cycle of its first change and the number of changes after each request.

// File: rtl/pds_pkg.sv
package pds_pkg;

   typedef enum logic [3:0] {
      ST_BOOT,
      ST_IDLE,
      ST_DN_SETTLE1,
      ST_DN_SETTLE2,
      ST_DN_CLKWAIT,
      ST_UP_SETTLE1,
      ST_UP_SETTLE2,
      ST_UP_ISO,
      ST_UP_RST,
      ST_UP_CLK
   } seq_state_e;

   function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
      return (a + b - 1) / b;
   endfunction

endpackage

// File: rtl/pds_delay_timer.sv
module pds_delay_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (load_i)         cnt_q <= len_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expire_o = (cnt_q == CNT_W'(1));

   // the controller may only start a wait when no wait is pending
   assert_tmr_load_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |-> (cnt_q == '0 || expire_o));

endmodule

// File: rtl/pds_mem_field_bank.sv
module pds_mem_field_bank #(
   parameter int FIELDS   = 8,
   parameter int FIELD_W  = 2,
   parameter int WORD_W   = 32,
   parameter bit INIT_SET = 1'b1,
   localparam int USED    = FIELDS * FIELD_W,
   localparam int WORDS   = (USED + WORD_W - 1) / WORD_W,
   localparam int BANK_W  = WORDS * WORD_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              set_i,
   input  logic              clr_i,
   output logic [BANK_W-1:0] mem_o
);

   function automatic logic [WORD_W-1:0] word_mask(input int w);
      logic [WORD_W-1:0] m;
      m = '0;
      for (int b = 0; b < WORD_W; b++) begin
         if (w * WORD_W + b < USED) m[b] = 1'b1;
      end
      return m;
   endfunction

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam logic [WORD_W-1:0] MASK = word_mask(w);
      logic [WORD_W-1:0] q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     q <= INIT_SET ? MASK : '0;
         else if (set_i)  q <= MASK;
         else if (clr_i)  q <= '0;
      end

      assign mem_o[w*WORD_W +: WORD_W] = q;
   end

   assert_set_clr_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(set_i && clr_i));

endmodule

// File: rtl/pds_ctrl_fsm.sv
module pds_ctrl_fsm
   import pds_pkg::*;
#(
   parameter bit HAS_SWITCH = 1'b1,
   parameter bit HAS_CLOCKS = 1'b1,
   parameter bit BOOT_ON    = 1'b0,
   parameter int CNT_W      = 8,
   parameter int SETTLE_CYC = 20,
   parameter int CLKW_CYC   = 100
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             on_req_i,
   input  logic             off_req_i,
   input  logic             shutdown_i,
   input  logic             tmr_expire_i,
   output logic             tmr_load_o,
   output logic [CNT_W-1:0] tmr_len_o,
   output logic             mem_set_o,
   output logic             mem_clr_o,
   output logic             sleep_o,
   output logic             iso_o,
   output logic             dom_rst_o,
   output logic             clk_en_o,
   output logic             pwr_on_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam logic [CNT_W-1:0] SETTLE_L = CNT_W'(SETTLE_CYC);
   localparam logic [CNT_W-1:0] CLKW_L   = CNT_W'(CLKW_CYC);
   localparam bit   AUTO_LOCK = BOOT_ON && HAS_SWITCH && HAS_CLOCKS;
   localparam logic SW_OFF0   = HAS_SWITCH && !BOOT_ON;

   seq_state_e st_q;
   logic sleep_q, iso_q, rst_q, clk_q, done_q, mem_on_q, locked_q;
   logic go_dn, go_up, noop;

   // request decode, only meaningful in idle
   always_comb begin
      go_dn = 1'b0;
      go_up = 1'b0;
      noop  = 1'b0;
      if (st_q == ST_IDLE) begin
         if (shutdown_i) begin
            if (pwr_on_o) go_dn = 1'b1;
            else          noop  = 1'b1;
         end else if (off_req_i) begin
            if (!locked_q) begin
               if (pwr_on_o) go_dn = 1'b1;
               else          noop  = 1'b1;
            end
         end else if (on_req_i) begin
            if (pwr_on_o) noop  = 1'b1;
            else          go_up = 1'b1;
         end
      end
   end

   // timer and memory-bank strobes
   always_comb begin
      tmr_load_o = 1'b0;
      tmr_len_o  = SETTLE_L;
      mem_set_o  = 1'b0;
      mem_clr_o  = 1'b0;
      unique case (st_q)
         ST_IDLE:       tmr_load_o = go_dn || go_up;
         ST_DN_SETTLE1: begin
            mem_set_o  = tmr_expire_i;
            tmr_load_o = tmr_expire_i;
         end
         ST_DN_SETTLE2: begin
            tmr_load_o = tmr_expire_i && HAS_CLOCKS;
            tmr_len_o  = CLKW_L;
         end
         ST_UP_SETTLE1: begin
            mem_clr_o  = tmr_expire_i;
            tmr_load_o = tmr_expire_i;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= AUTO_LOCK ? ST_BOOT : ST_IDLE;
         sleep_q  <= SW_OFF0;
         iso_q    <= SW_OFF0;
         rst_q    <= 1'b0;
         clk_q    <= 1'b0;
         done_q   <= 1'b0;
         mem_on_q <= BOOT_ON;
         locked_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_BOOT: begin
               clk_q    <= 1'b1;
               locked_q <= 1'b1;
               st_q     <= ST_IDLE;
            end
            ST_IDLE: begin
               if (go_dn) begin
                  sleep_q  <= HAS_SWITCH;
                  locked_q <= 1'b0;
                  st_q     <= ST_DN_SETTLE1;
               end else if (go_up) begin
                  sleep_q <= 1'b0;
                  st_q    <= ST_UP_SETTLE1;
               end else if (noop) begin
                  done_q <= 1'b1;
               end
            end
            ST_DN_SETTLE1: if (tmr_expire_i) begin
               mem_on_q <= 1'b0;
               st_q     <= ST_DN_SETTLE2;
            end
            ST_DN_SETTLE2: if (tmr_expire_i) begin
               iso_q <= HAS_SWITCH;
               if (HAS_CLOCKS) begin
                  st_q <= ST_DN_CLKWAIT;
               end else begin
                  clk_q  <= 1'b0;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end
            end
            ST_DN_CLKWAIT: if (tmr_expire_i) begin
               clk_q  <= 1'b0;
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            ST_UP_SETTLE1: if (tmr_expire_i) begin
               mem_on_q <= 1'b1;
               st_q     <= ST_UP_SETTLE2;
            end
            ST_UP_SETTLE2: if (tmr_expire_i) begin
               rst_q <= 1'b1;
               st_q  <= ST_UP_ISO;
            end
            ST_UP_ISO: begin
               iso_q <= 1'b0;
               st_q  <= ST_UP_RST;
            end
            ST_UP_RST: begin
               rst_q <= 1'b0;
               st_q  <= ST_UP_CLK;
            end
            ST_UP_CLK: begin
               clk_q  <= HAS_CLOCKS;
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign sleep_o   = sleep_q;
   assign iso_o     = iso_q;
   assign dom_rst_o = rst_q;
   assign clk_en_o  = clk_q;
   assign done_o    = done_q;
   assign busy_o    = (st_q != ST_IDLE);
   assign pwr_on_o  = HAS_SWITCH ? !sleep_q : mem_on_q;

   assert_iso_release_in_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(iso_o) |-> dom_rst_o);

   assert_clk_on_clean_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_en_o) |-> (!dom_rst_o && !iso_o && !sleep_o));

   assert_done_when_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   assert_sleep_from_unisolated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sleep_o) |-> $past(!iso_o));

   assert_lock_blocks_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (locked_q && st_q == ST_IDLE && off_req_i && !shutdown_i)
      |=> ($stable(sleep_o) && !done_o && st_q == ST_IDLE));

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
   import pds_pkg::*;
#(
   parameter int CYC_PER_US  = 100,
   parameter int SETTLE_US   = 20,
   parameter int CLK_WAIT_US = 20000,
   parameter bit HAS_SWITCH  = 1'b1,
   parameter bit HAS_CLOCKS  = 1'b1,
   parameter bit BOOT_ON     = 1'b0,
   parameter int MEM_FIELDS  = 40,
   parameter int FIELD_W     = 2,
   parameter int WORD_W      = 32,
   localparam int USED_BITS  = MEM_FIELDS * FIELD_W,
   localparam int MEM_WORDS  = int'(ceil_div(USED_BITS, WORD_W)),
   localparam int MEM_W      = MEM_WORDS * WORD_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             on_req_i,
   input  logic             off_req_i,
   input  logic             shutdown_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             pwr_on_o,
   output logic             sleep_o,
   output logic             iso_o,
   output logic [MEM_W-1:0] mem_pd_o,
   output logic             dom_rst_o,
   output logic             clk_en_o
);

   localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
   localparam int CLKW_CYC   = CYC_PER_US * CLK_WAIT_US;
   localparam int MAX_CYC    = (SETTLE_CYC > CLKW_CYC) ? SETTLE_CYC : CLKW_CYC;
   localparam int CNT_W      = $clog2(MAX_CYC + 1);

   if (WORD_W % FIELD_W != 0) begin : g_bad_pack
      $error("WORD_W must hold a whole number of fields");
   end
   if (MEM_FIELDS < 1) begin : g_bad_fields
      $error("MEM_FIELDS must be at least one");
   end
   if (SETTLE_CYC < 1 || CLKW_CYC < 1) begin : g_bad_wait
      $error("settle and clock waits must be at least one cycle");
   end

   function automatic logic [MEM_W-1:0] full_mask();
      logic [MEM_W-1:0] m;
      m = '0;
      for (int b = 0; b < USED_BITS; b++) m[b] = 1'b1;
      return m;
   endfunction
   localparam logic [MEM_W-1:0] FULL = full_mask();

   logic             tmr_load, tmr_expire, mem_set, mem_clr;
   logic [CNT_W-1:0] tmr_len;

   pds_ctrl_fsm #(
      .HAS_SWITCH (HAS_SWITCH),
      .HAS_CLOCKS (HAS_CLOCKS),
      .BOOT_ON    (BOOT_ON),
      .CNT_W      (CNT_W),
      .SETTLE_CYC (SETTLE_CYC),
      .CLKW_CYC   (CLKW_CYC)
   ) fsm_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .on_req_i     (on_req_i),
      .off_req_i    (off_req_i),
      .shutdown_i   (shutdown_i),
      .tmr_expire_i (tmr_expire),
      .tmr_load_o   (tmr_load),
      .tmr_len_o    (tmr_len),
      .mem_set_o    (mem_set),
      .mem_clr_o    (mem_clr),
      .sleep_o      (sleep_o),
      .iso_o        (iso_o),
      .dom_rst_o    (dom_rst_o),
      .clk_en_o     (clk_en_o),
      .pwr_on_o     (pwr_on_o),
      .busy_o       (busy_o),
      .done_o       (done_o)
   );

   pds_delay_timer #(.CNT_W(CNT_W)) tmr_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (tmr_load),
      .len_i    (tmr_len),
      .expire_o (tmr_expire)
   );

   pds_mem_field_bank #(
      .FIELDS   (MEM_FIELDS),
      .FIELD_W  (FIELD_W),
      .WORD_W   (WORD_W),
      .INIT_SET (!BOOT_ON)
   ) bank_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (mem_set),
      .clr_i  (mem_clr),
      .mem_o  (mem_pd_o)
   );

   assert_iso_after_mem_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(iso_o) |-> (mem_pd_o == FULL));

   assert_mem_clear_while_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_en_o) |-> (mem_pd_o == '0));

endmodule

// File: tb/pwr_domain_seq_tb_top.sv
module pwr_domain_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CPU = 2;
   localparam int SUS = 3;
   localparam int CUS = 5;
   localparam int N   = CPU * SUS;   // settle cycles
   localparam int C   = CPU * CUS;   // clock-wait cycles
   localparam int B_SLP = 6, B_ISO = 5, B_RST = 4, B_CLK = 3, B_PWR = 2, B_MEM = 0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic on_r[3], off_r[3], sd_r[3];
   logic busy[3], done[3], pwr[3], slp[3], iso[3], drst[3], cken[3];
   logic [63:0] mem_a;
   logic [31:0] mem_b, mem_c;

   pwr_domain_seq #(.CYC_PER_US(CPU), .SETTLE_US(SUS), .CLK_WAIT_US(CUS),
      .HAS_SWITCH(1'b1), .HAS_CLOCKS(1'b1), .BOOT_ON(1'b0), .MEM_FIELDS(20)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .on_req_i(on_r[0]), .off_req_i(off_r[0]),
      .shutdown_i(sd_r[0]), .busy_o(busy[0]), .done_o(done[0]), .pwr_on_o(pwr[0]),
      .sleep_o(slp[0]), .iso_o(iso[0]), .mem_pd_o(mem_a), .dom_rst_o(drst[0]),
      .clk_en_o(cken[0]));

   pwr_domain_seq #(.CYC_PER_US(CPU), .SETTLE_US(SUS), .CLK_WAIT_US(CUS),
      .HAS_SWITCH(1'b0), .HAS_CLOCKS(1'b0), .BOOT_ON(1'b0), .MEM_FIELDS(6)) dut_mem_i (
      .clk_i(clk), .rst_ni(rst_n), .on_req_i(on_r[1]), .off_req_i(off_r[1]),
      .shutdown_i(sd_r[1]), .busy_o(busy[1]), .done_o(done[1]), .pwr_on_o(pwr[1]),
      .sleep_o(slp[1]), .iso_o(iso[1]), .mem_pd_o(mem_b), .dom_rst_o(drst[1]),
      .clk_en_o(cken[1]));

   pwr_domain_seq #(.CYC_PER_US(CPU), .SETTLE_US(SUS), .CLK_WAIT_US(CUS),
      .HAS_SWITCH(1'b1), .HAS_CLOCKS(1'b1), .BOOT_ON(1'b1), .MEM_FIELDS(16)) dut_aon_i (
      .clk_i(clk), .rst_ni(rst_n), .on_req_i(on_r[2]), .off_req_i(off_r[2]),
      .shutdown_i(sd_r[2]), .busy_o(busy[2]), .done_o(done[2]), .pwr_on_o(pwr[2]),
      .sleep_o(slp[2]), .iso_o(iso[2]), .mem_pd_o(mem_c), .dom_rst_o(drst[2]),
      .clk_en_o(cken[2]));

   function automatic logic [63:0] used_mask(input int fields);
      logic [63:0] m = '0;
      for (int b = 0; b < fields * 2; b++) m[b] = 1'b1;
      return m;
   endfunction

   // 1 = used fields all ones and rest zero, 0 = all zero, 2 = anything else
   function automatic logic [1:0] mem_code(input logic [63:0] v, input int fields);
      if (v == used_mask(fields)) return 2'd1;
      if (v == '0)                return 2'd0;
      return 2'd2;
   endfunction

   int sel = 0;
   logic [6:0] obs;
   always_comb begin
      logic [1:0] mc;
      case (sel)
         0:       mc = mem_code(mem_a, 20);
         1:       mc = mem_code({32'd0, mem_b}, 6);
         default: mc = mem_code({32'd0, mem_c}, 16);
      endcase
      obs = {slp[sel], iso[sel], drst[sel], cken[sel], pwr[sel], mc};
   end

   int n_chk = 0, n_fail = 0;
   int fc[7], nc[7];
   int done_first, done_cnt, busy_cnt;
   bit finished = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic run_seq(input int s, input bit on_b, input bit off_b, input bit sd_b,
                          input int mid_idx, input bit mid_on, input bit mid_off,
                          input int len);
      logic [6:0] prev;
      sel = s;
      @(negedge clk);
      prev = obs;
      for (int k = 0; k < 7; k++) begin fc[k] = -1; nc[k] = 0; end
      done_first = -1; done_cnt = 0; busy_cnt = 0;
      on_r[s] = on_b; off_r[s] = off_b; sd_r[s] = sd_b;
      @(posedge clk);
      @(negedge clk);
      on_r[s] = 1'b0; off_r[s] = 1'b0; sd_r[s] = 1'b0;
      for (int i = 0; i < len; i++) begin
         if (i > 0) @(negedge clk);
         for (int k = 0; k < 7; k++) begin
            if (obs[k] != prev[k]) begin
               if (fc[k] < 0) fc[k] = i;
               nc[k]++;
            end
         end
         prev = obs;
         if (done[s]) begin
            if (done_first < 0) done_first = i;
            done_cnt++;
         end
         if (busy[s]) busy_cnt++;
         if (i == mid_idx) begin on_r[s] = mid_on; off_r[s] = mid_off; end
         if (i == mid_idx + 1) begin on_r[s] = 1'b0; off_r[s] = 1'b0; end
      end
   endtask

   initial begin
      for (int d = 0; d < 3; d++) begin on_r[d] = 0; off_r[d] = 0; sd_r[d] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, switched domain
      chk("R1 sleep", slp[0], 1);
      chk("R1 iso", iso[0], 1);
      chk("R1 mem fields", (mem_a == used_mask(20)) ? 1 : 0, 1);
      chk("R1 rst", drst[0], 0);
      chk("R1 clk", cken[0], 0);
      chk("R1 pwr", pwr[0], 0);
      chk("R1 busy", busy[0], 0);
      chk("R1 done", done[0], 0);
      // R1/R6 memory-only reset
      chk("R6 sleep tied", slp[1], 0);
      chk("R6 iso tied", iso[1], 0);
      chk("R1 mem-only fields", (mem_b == used_mask(6)) ? 1 : 0, 1);
      // R8 boot-on domain
      chk("R8 boot clk", cken[2], 1);
      chk("R8 boot sleep", slp[2], 0);
      chk("R8 boot mem", (mem_c == 32'd0) ? 1 : 0, 1);
      chk("R8 boot pwr", pwr[2], 1);
      chk("R8 boot busy", busy[2], 0);

      // R3 power-up of switched domain
      run_seq(0, 1, 0, 0, -1, 0, 0, 40);
      chk("R3 sleep idx", fc[B_SLP], 0);
      chk("R7 pwr idx", fc[B_PWR], 0);
      chk("R3 mem idx", fc[B_MEM], N);
      chk("R3 rst rise idx", fc[B_RST], 2*N);
      chk("R3 rst edges", nc[B_RST], 2);
      chk("R3 iso idx", fc[B_ISO], 2*N+1);
      chk("R3 clk idx", fc[B_CLK], 2*N+3);
      chk("R4 done idx", done_first, 2*N+3);
      chk("R4 done cnt", done_cnt, 1);
      chk("R4 busy cycles", busy_cnt, 2*N+3);
      chk("R3 mem final", int'(obs[1:0]), 0);
      chk("R3 rst final", drst[0], 0);

      // R5 on while on
      run_seq(0, 1, 0, 0, -1, 0, 0, 10);
      chk("R5 done idx", done_first, 0);
      chk("R5 done cnt", done_cnt, 1);
      chk("R5 busy", busy_cnt, 0);
      chk("R5 changes", nc[B_SLP]+nc[B_ISO]+nc[B_RST]+nc[B_CLK]+nc[B_MEM], 0);

      // R2 power-down with an on request while busy (R4 ignore)
      run_seq(0, 0, 1, 0, 3, 1, 0, 40);
      chk("R2 sleep idx", fc[B_SLP], 0);
      chk("R7 pwr off idx", fc[B_PWR], 0);
      chk("R2 mem idx", fc[B_MEM], N);
      chk("R2 iso idx", fc[B_ISO], 2*N);
      chk("R2 clk idx", fc[B_CLK], 2*N+C);
      chk("R2 rst untouched", nc[B_RST], 0);
      chk("R4 done off idx", done_first, 2*N+C);
      chk("R4 ignore mid on", done_cnt, 1);
      chk("R4 sleep edges", nc[B_SLP], 1);
      chk("R2 mem final", int'(obs[1:0]), 1);

      // R5 off while off
      run_seq(0, 0, 1, 0, -1, 0, 0, 10);
      chk("R5 off noop done", done_first, 0);
      chk("R5 off noop changes", nc[B_SLP]+nc[B_ISO]+nc[B_MEM]+nc[B_CLK], 0);

      // R9 on+off together while off: off wins -> no-op
      run_seq(0, 1, 1, 0, -1, 0, 0, 10);
      chk("R9 prio off over on done", done_first, 0);
      chk("R9 prio off over on sleep", nc[B_SLP], 0);

      // bring up, then shutdown together with on: shutdown wins
      run_seq(0, 1, 0, 0, -1, 0, 0, 40);
      run_seq(0, 1, 0, 1, -1, 0, 0, 40);
      chk("R9 shutdown sleep idx", fc[B_SLP], 0);
      chk("R9 shutdown clk idx", fc[B_CLK], 2*N+C);
      chk("R9 shutdown done", done_first, 2*N+C);

      // R6 memory-only power-up
      run_seq(1, 1, 0, 0, -1, 0, 0, 40);
      chk("R6 no sleep", nc[B_SLP], 0);
      chk("R6 no iso", nc[B_ISO], 0);
      chk("R6 mem idx", fc[B_MEM], N);
      chk("R6 rst idx", fc[B_RST], 2*N);
      chk("R6 rst edges", nc[B_RST], 2);
      chk("R10 clk stays", nc[B_CLK], 0);
      chk("R6 done idx", done_first, 2*N+3);
      chk("R7 mem-only pwr idx", fc[B_PWR], N);

      // R10 memory-only power-down without clock wait
      run_seq(1, 0, 1, 0, -1, 0, 0, 40);
      chk("R6 off mem idx", fc[B_MEM], N);
      chk("R10 done idx", done_first, 2*N);
      chk("R10 busy cycles", busy_cnt, 2*N);
      chk("R7 mem-only pwr off", fc[B_PWR], N);
      chk("R6 off final mem", int'(obs[1:0]), 1);

      // R8 off request to locked domain
      run_seq(2, 0, 1, 0, -1, 0, 0, 40);
      chk("R8 lock no done", done_cnt, 0);
      chk("R8 lock no busy", busy_cnt, 0);
      chk("R8 lock no change", nc[B_SLP]+nc[B_ISO]+nc[B_MEM]+nc[B_CLK], 0);

      // R9 shutdown overrides lock
      run_seq(2, 0, 0, 1, -1, 0, 0, 40);
      chk("R9 aon sleep idx", fc[B_SLP], 0);
      chk("R9 aon mem idx", fc[B_MEM], N);
      chk("R9 aon iso idx", fc[B_ISO], 2*N);
      chk("R9 aon clk idx", fc[B_CLK], 2*N+C);
      chk("R9 aon done", done_first, 2*N+C);

      // power-up after shutdown behaves normally
      run_seq(2, 1, 0, 0, -1, 0, 0, 40);
      chk("R3 aon clk idx", fc[B_CLK], 2*N+3);
      chk("R3 aon done", done_first, 2*N+3);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule